// File: doc/BRIEF.md
# Serial Control Word Receiver with Dual Frequency Buffers

This block takes control words from a three-pin serial port (data, clock, enable) and spreads them over holding buffers that feed a frequency synthesiser's dividers and phase detector. Bits enter a shift register while enable is high. When enable falls, the two bits shifted in last pick the destination. The destination is one of two frequency buffers, a reference buffer, or a short update that rewrites only the A field of the buffer now in use.

Two frequency buffers hold complete alternatives: the M and A divider values, the charge pump gain code and the phase detector sense bit. A level pin picks which of the two drives the outputs. Software can fill the idle buffer at leisure and then hop frequency or loop gain by flipping that pin. All pin inputs are synchronised to the system clock. Edges of the serial clock and of the enable are found by edge detection on the system clock.

Top module: `ctl_serial_if`

## Requirements
- R1: After reset both frequency buffers and the reference buffer hold zero, so every output reads zero.
- R2: The shift register moves one place toward its MSB and takes the new bit at bit 0 on each rising serial clock edge seen while enable is high. Serial clock edges while enable is low are ignored. A short frame therefore leaves the earlier contents shifted up above it.
- R3: Outputs do not change while a frame is being shifted. Buffers are written only on the falling edge of enable.
- R4: Select code {bit1,bit0} = 00 loads buffer F1 from bits 23..2. Bit 2 is the sense bit, bits 6..3 are A, bits 21..7 are M, and bits 23..22 are the gain code, with bit 23 as the upper gain bit.
- R5: Select code 10 loads buffer F2, using the same field layout as R4.
- R6: When sel_f1 is high, F1 drives div_m, div_a, cp_gain and pd_sense. When it is low, F2 drives them. Writing the inactive buffer leaves the outputs unchanged.
- R7: Select code 01 copies bits 5..2 into the A field of the active buffer only. M, gain and sense of that buffer stay unchanged, and the other buffer is not touched.
- R8: Select code 11 loads the reference buffer. Bit 2 is the prescaler mode (1 selects the 8/9 ratio), bits 4..3 are pd_ctl with bit 4 as pd_ctl[1], and bits 17..5 are the reference divider value. The frequency buffers are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial clock pin; rising edge shifts |
| ser_en | input | 1 | Frame enable pin; falling edge loads |
| sel_f1 | input | 1 | High selects F1 as active buffer, low selects F2 |
| div_m | output | 15 | M divider value of the active buffer |
| div_a | output | 4 | A divider value of the active buffer |
| cp_gain | output | 2 | Charge pump gain code of the active buffer |
| pd_sense | output | 1 | Phase detector sense of the active buffer |
| ref_r | output | 13 | Reference divider value |
| pd_ctl | output | 2 | Charge pump and divider output control bits |
| pre_mode | output | 1 | Prescaler ratio select, 1 = 8/9 |

## Verification
A buffer written with the wrong select code, or a field taken from the wrong bit positions, shows on the outputs within a few system clocks of enable falling. For the inactive buffer, the fault shows as soon as sel_f1 is flipped. A shift register that also moves while enable is low stays hidden behind full-length frames. It only appears when a short frame loads bits that were shifted in earlier, so that case is driven on purpose. An active-A update that lands in the wrong buffer is visible only after the select pin swaps buffers, so both buffers are read back after such an update.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
   typedef enum logic [1:0] {
      SEL_F1    = 2'b00,
      SEL_AONLY = 2'b01,
      SEL_F2    = 2'b10,
      SEL_REF   = 2'b11
   } frame_sel_e;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/ctl_shift.sv
module ctl_shift #(
   parameter int SR_W = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift,
   input  logic            bit_in,
   output logic [SR_W-1:0] sr
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     sr <= '0;
      else if (shift) sr <= {sr[SR_W-2:0], bit_in};
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
   import ctl_pkg::*;
#(
   parameter int M_W = 15,
   parameter int A_W = 4,
   parameter int G_W = 2,
   parameter int R_W = 13,
   localparam int FW   = G_W + M_W + A_W + 1,
   localparam int SR_W = FW + 2,
   localparam int RB_W = R_W + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [SR_W-1:0] sr,
   input  logic            sel_f1,
   output logic [M_W-1:0]  div_m,
   output logic [A_W-1:0]  div_a,
   output logic [G_W-1:0]  cp_gain,
   output logic            pd_sense,
   output logic [R_W-1:0]  ref_r,
   output logic [1:0]      pd_ctl,
   output logic            pre_mode
);
   frame_sel_e code;
   assign code = frame_sel_e'(sr[1:0]);

   // index 0 = F1, index 1 = F2
   for (genvar gi = 0; gi < 2; gi++) begin : g_buf
      localparam logic [1:0] MY_CODE = (gi == 0) ? 2'b00 : 2'b10;
      logic         is_act;
      logic [FW-1:0] word_q;
      assign is_act = (gi == 0) ? sel_f1 : !sel_f1;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) word_q <= '0;
         else if (ld) begin
            if (sr[1:0] == MY_CODE)
               word_q <= sr[SR_W-1:2];
            else if (code == SEL_AONLY && is_act)
               word_q[1 +: A_W] <= sr[2 +: A_W];
         end
   end

   logic [RB_W-1:0] rbuf_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      rbuf_q <= '0;
      else if (ld && code == SEL_REF)  rbuf_q <= sr[RB_W+1:2];

   logic [FW-1:0] act_w;
   assign act_w    = sel_f1 ? g_buf[0].word_q : g_buf[1].word_q;
   assign pd_sense = act_w[0];
   assign div_a    = act_w[A_W:1];
   assign div_m    = act_w[A_W+M_W:A_W+1];
   assign cp_gain  = act_w[FW-1:FW-G_W];
   assign pre_mode = rbuf_q[0];
   assign pd_ctl   = rbuf_q[2:1];
   assign ref_r    = rbuf_q[RB_W-1:3];
endmodule

// File: rtl/ctl_serial_if.sv
module ctl_serial_if #(
   parameter int M_W         = 15,
   parameter int A_W         = 4,
   parameter int G_W         = 2,
   parameter int R_W         = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_data,
   input  logic           ser_clk,
   input  logic           ser_en,
   input  logic           sel_f1,
   output logic [M_W-1:0] div_m,
   output logic [A_W-1:0] div_a,
   output logic [G_W-1:0] cp_gain,
   output logic           pd_sense,
   output logic [R_W-1:0] ref_r,
   output logic [1:0]     pd_ctl,
   output logic           pre_mode
);
   localparam int FW   = G_W + M_W + A_W + 1;
   localparam int SR_W = FW + 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (R_W + 5 > SR_W) begin : g_bad_ref
      $error("reference frame does not fit in the shift register");
   end
   if (A_W < 1 || M_W < 1 || G_W < 1) begin : g_bad_field
      $error("field widths must be positive");
   end

   logic dat_s, sck_s, en_s, sel_s;
   ctl_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_data, ser_clk, ser_en, sel_f1}),
      .q({dat_s, sck_s, en_s, sel_s})
   );

   logic sck_d, en_d;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sck_d <= 1'b0;
         en_d  <= 1'b0;
      end else begin
         sck_d <= sck_s;
         en_d  <= en_s;
      end

   logic shift_pulse, ld_pulse;
   assign shift_pulse = en_s & sck_s & ~sck_d;
   assign ld_pulse    = en_d & ~en_s;

   logic [SR_W-1:0] sr_q;
   ctl_shift #(.SR_W(SR_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift(shift_pulse), .bit_in(dat_s), .sr(sr_q)
   );

   ctl_bank #(.M_W(M_W), .A_W(A_W), .G_W(G_W), .R_W(R_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .ld(ld_pulse), .sr(sr_q), .sel_f1(sel_s),
      .div_m(div_m), .div_a(div_a), .cp_gain(cp_gain), .pd_sense(pd_sense),
      .ref_r(ref_r), .pd_ctl(pd_ctl), .pre_mode(pre_mode)
   );
endmodule

// File: rtl/ctl_serial_if_chk.sv
module ctl_serial_if_chk #(
   parameter int M_W  = 15,
   parameter int A_W  = 4,
   parameter int G_W  = 2,
   parameter int R_W  = 13,
   parameter int SR_W = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ld_pulse,
   input logic            en_s,
   input logic            sel_s,
   input logic [SR_W-1:0] sr_q,
   input logic [M_W-1:0]  div_m,
   input logic [A_W-1:0]  div_a,
   input logic [G_W-1:0]  cp_gain,
   input logic            pd_sense,
   input logic [R_W-1:0]  ref_r,
   input logic [1:0]      pd_ctl,
   input logic            pre_mode
);
   assert_shift_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sr_q) |-> $past(en_s));

   assert_hold_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({cp_gain, div_m, div_a, pd_sense}) |-> ($past(ld_pulse) || !$stable(sel_s)));

   assert_aonly_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_pulse && sr_q[1:0] == 2'b01) |=>
         (!$stable(sel_s) || ($stable(div_m) && $stable(cp_gain) && $stable(pd_sense))));

   assert_ref_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({ref_r, pd_ctl, pre_mode}) |-> $past(ld_pulse && sr_q[1:0] == 2'b11));
endmodule

bind ctl_serial_if ctl_serial_if_chk #(
   .M_W(M_W), .A_W(A_W), .G_W(G_W), .R_W(R_W), .SR_W(SR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_pulse(ld_pulse), .en_s(en_s), .sel_s(sel_s),
   .sr_q(sr_q), .div_m(div_m), .div_a(div_a), .cp_gain(cp_gain),
   .pd_sense(pd_sense), .ref_r(ref_r), .pd_ctl(pd_ctl), .pre_mode(pre_mode)
);

// File: tb/tb_ctl_serial_if.sv
module tb_ctl_serial_if;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0, sel_f1 = 1'b0;
   logic [14:0] div_m;
   logic [3:0]  div_a;
   logic [1:0]  cp_gain;
   logic        pd_sense;
   logic [12:0] ref_r;
   logic [1:0]  pd_ctl;
   logic        pre_mode;

   always #10 clk = ~clk;

   ctl_serial_if dut (
      .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
      .ser_en(ser_en), .sel_f1(sel_f1), .div_m(div_m), .div_a(div_a),
      .cp_gain(cp_gain), .pd_sense(pd_sense), .ref_r(ref_r), .pd_ctl(pd_ctl),
      .pre_mode(pre_mode)
   );

   typedef struct {
      int          kind;   // 0 = active frequency view, 1 = reference view
      logic [21:0] val;
      string       req;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;
   logic [21:0] exp_f1 = '0, exp_f2 = '0;
   logic [15:0] exp_ref = '0;

   // monitor: pops expected items and compares against outputs
   initial begin
      forever begin
         exp_t it;
         wait (q.size() > 0);
         it = q.pop_front();
         checks++;
         if (it.kind == 0) begin
            if ({cp_gain, div_m, div_a, pd_sense} !== it.val) begin
               errors++;
               $display("FAIL %s: active word %h expected %h", it.req,
                        {cp_gain, div_m, div_a, pd_sense}, it.val);
            end
         end else begin
            if ({ref_r, pd_ctl, pre_mode} !== it.val[15:0]) begin
               errors++;
               $display("FAIL %s: reference word %h expected %h", it.req,
                        {ref_r, pd_ctl, pre_mode}, it.val[15:0]);
            end
         end
      end
   end

   function automatic logic [21:0] fw(input logic [1:0] g, input logic [14:0] m,
                                      input logic [3:0] a, input logic s);
      return {g, m, a, s};
   endfunction

   task automatic half_bit();
      repeat (4) @(posedge clk);
   endtask

   task automatic expect_act(input string req);
      exp_t it;
      @(negedge clk);
      it.kind = 0;
      it.val  = sel_f1 ? exp_f1 : exp_f2;
      it.req  = req;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   task automatic expect_ref(input string req);
      exp_t it;
      @(negedge clk);
      it.kind = 1;
      it.val  = {6'b0, exp_ref};
      it.req  = req;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   // driver: one frame, MSB first, n bits
   task automatic send(input logic [23:0] w, input int n, input bit mid);
      ser_en = 1'b1;
      half_bit();
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = w[i];
         half_bit();
         ser_clk = 1'b1;
         half_bit();
         ser_clk = 1'b0;
         if (mid && i == n / 2) expect_act("R3 outputs held mid-frame");
      end
      half_bit();
      ser_en = 1'b0;
      repeat (8) @(posedge clk);
   endtask

   task automatic set_sel(input logic v);
      sel_f1 = v;
      repeat (6) @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [21:0] w1, w2, w3, w4;
      repeat (10) @(posedge clk);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      expect_act("R1 reset frequency view");
      expect_ref("R1 reset reference view");

      set_sel(1'b1);
      w1 = fw(2'b10, 15'h1234, 4'h5, 1'b1);
      send({w1, 2'b00}, 24, 1'b1);
      exp_f1 = w1;
      expect_act("R4 F1 load");

      w2 = fw(2'b01, 15'h0456, 4'h9, 1'b0);
      send({w2, 2'b10}, 24, 1'b0);
      exp_f2 = w2;
      expect_act("R6 inactive F2 write leaves outputs");

      set_sel(1'b0);
      expect_act("R5 F2 contents after select swap");

      send({18'b0, 4'h3, 2'b01}, 6, 1'b0);
      exp_f2[4:1] = 4'h3;
      expect_act("R7 A-only update on active F2");

      set_sel(1'b1);
      expect_act("R7 F1 untouched by A-only update");

      send({6'b0, 13'h1ABC, 2'b10, 1'b1, 2'b11}, 18, 1'b0);
      exp_ref = {13'h1ABC, 2'b10, 1'b1};
      expect_ref("R8 reference load");
      expect_act("R8 frequency view untouched");

      send({6'b0, 13'h0001, 2'b01, 1'b0, 2'b11}, 18, 1'b0);
      exp_ref = {13'h0001, 2'b01, 1'b0};
      expect_ref("R8 reference second pattern");

      w3 = fw(2'b11, 15'h7FFF, 4'hF, 1'b1);
      send({w3, 2'b00}, 24, 1'b0);
      exp_f1 = w3;
      expect_act("R4 all-ones F1 word");

      send({18'b0, 4'hA, 2'b01}, 6, 1'b0);
      exp_f1[4:1] = 4'hA;
      expect_act("R7 A-only update on active F1");
      set_sel(1'b0);
      expect_act("R7 F2 untouched by A-only update");
      set_sel(1'b1);

      w4 = fw(2'b01, 15'h2AAA, 4'hC, 1'b0);
      send({w4, 2'b00}, 24, 1'b0);
      exp_f1 = w4;
      expect_act("R4 F1 reload");
      // clock pulses with enable low must not shift
      ser_data = 1'b1;
      for (int k = 0; k < 8; k++) begin
         half_bit();
         ser_clk = 1'b1;
         half_bit();
         ser_clk = 1'b0;
      end
      ser_data = 1'b0;
      send(24'h000000, 2, 1'b0);
      exp_f1 = {w4[19:0], 2'b00};
      expect_act("R2 short frame keeps shifted bits, ignored clocks");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule